// File: doc/BRIEF.md
# Parallel-Lane DDS Phase Accumulator

This block produces the phase words for a direct digital synthesizer whose fabric clock is slower than the converter's sample clock. On each fabric clock it outputs `LANES` phase words. These are the phases of `LANES` consecutive converter samples. Lane 0 carries the earliest sample, and each higher lane is one frequency word further along. A sine converter and an amplitude stage sit downstream, one per lane. This block only supplies their phase inputs.

While the accumulator runs, every lane moves forward by `LANES` times the frequency word on each clock that has `sample_en` set. The sample stream therefore stays continuous from one fabric clock to the next. If the frequency word or the initial phase changes, the block realigns all lanes to the new settings. While `sync_in` is high, every lane is forced to zero and the valid flag is cleared. The hold always lasts at least `LANES` clocks, even when the sync pulse is shorter. On the first clock after the hold ends, the lanes reload from the initial phase.

Top module: `dds_lane_phase_acc`

## Requirements
- R1: While reset is asserted, `phase_valid` is 0 and every lane of `lane_phase` is 0.
- R2: On the first clock edge after reset with no hold active, lane k (bits [k*PW +: PW]) loads `phase_init + k*freq_word` modulo 2^PW and `phase_valid` goes to 1.
- R3: When `phase_valid` is 1, the settings are unchanged and `sample_en` is 1, each lane grows by `LANES*freq_word` at the next clock edge.
- R4: All lane arithmetic wraps modulo 2^PW with no saturation.
- R5: When `sample_en` is 0 and no hold or realignment takes place, every lane keeps its value.
- R6: When `freq_word` or `phase_init` differs from the values last loaded, the next clock edge reloads all lanes as in R2, whatever the value of `sample_en`.
- R7: At any clock edge where `sync_in` is 1, every lane becomes 0 and `phase_valid` becomes 0.
- R8: A sync pulse shorter than `LANES` clocks still holds the lanes at zero, with `phase_valid` at 0, for exactly `LANES` clock edges counted from its first high edge.
- R9: On the first clock edge after the hold ends, the lanes reload as in R2 and `phase_valid` returns to 1. For a pulse of at least `LANES` clocks, this is the first edge at which `sync_in` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Advance the accumulator on this clock |
| sync_in | input | 1 | Phase sync; lanes held at zero while high |
| freq_word | input | PW | Per-sample phase increment |
| phase_init | input | PW | Phase of lane 0 after alignment |
| lane_phase | output | LANES*PW | Lane k phase in bits [k*PW +: PW] |
| phase_valid | output | 1 | Lanes carry aligned phases |

## Verification
The hardest case to reach is a sync pulse that ends before the minimum hold has run out. The ports give no direct view of the stretch counter, so the only evidence is how long the zeros and the low valid flag last after `sync_in` has already dropped. The bench sweeps the pulse width from one clock up past `LANES`. For each width it checks every clock of the hold and the reload clock that follows, and it mixes in pulses that start right after a reprogramming realignment.

// File: rtl/dds_lane_phase_acc.sv
module dds_lane_phase_acc #(
  parameter int LANES = 4,
  parameter int PW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                sync_in,
  input  logic [PW-1:0]       freq_word,
  input  logic [PW-1:0]       phase_init,
  output logic [LANES*PW-1:0] lane_phase,
  output logic                phase_valid
);

  localparam int CW = $clog2(LANES + 1);

  logic [CW-1:0] held;
  logic [PW-1:0] fw_q, init_q;
  logic          valid_q;
  logic          hold, cfg_changed, align;
  logic [PW-1:0] stride;

  assign hold        = sync_in || (held != '0 && held < CW'(LANES));
  assign cfg_changed = (freq_word != fw_q) || (phase_init != init_q);
  assign align       = !hold && (!valid_q || cfg_changed);
  assign stride      = PW'(fw_q * LANES);
  assign phase_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else if (hold) held <= (held == CW'(LANES)) ? held : held + 1'b1;
    else held <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fw_q    <= '0;
      init_q  <= '0;
    end else if (hold) begin
      valid_q <= 1'b0;
    end else if (align) begin
      valid_q <= 1'b1;
      fw_q    <= freq_word;
      init_q  <= phase_init;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PW-1:0] acc;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else if (hold) acc <= '0;
      else if (align) acc <= phase_init + PW'(k) * freq_word;
      else if (sample_en) acc <= acc + stride;
    end
    assign lane_phase[k*PW +: PW] = acc;
  end

endmodule

module dds_lane_phase_acc_chk #(
  parameter int LANES = 4,
  parameter int PW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_en,
  input logic                sync_in,
  input logic [PW-1:0]       freq_word,
  input logic [PW-1:0]       phase_init,
  input logic                hold,
  input logic [PW-1:0]       fw_q,
  input logic [PW-1:0]       init_q,
  input logic [LANES*PW-1:0] lane_phase,
  input logic                phase_valid
);

  logic [PW-1:0] lane0;
  logic          same_cfg;
  assign lane0    = lane_phase[PW-1:0];
  assign same_cfg = (freq_word == fw_q) && (phase_init == init_q);

  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (!phase_valid && lane_phase == '0));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid && sample_en && !hold && same_cfg)
      |=> lane0 == PW'($past(lane0) + $past(fw_q) * LANES));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid && !sample_en && !hold && same_cfg) |=> $stable(lane_phase));

  p_realign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid && !hold && !same_cfg) |=> lane0 == $past(phase_init));

  p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !phase_valid) |=> phase_valid);

  for (genvar k = 1; k < LANES; k++) begin : g_space
    p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phase_valid |-> PW'(lane_phase[k*PW +: PW] - lane_phase[(k-1)*PW +: PW]) == fw_q);
  end

endmodule

bind dds_lane_phase_acc dds_lane_phase_acc_chk #(.LANES(LANES), .PW(PW)) u_chk (.*);

// File: tb/dds_lane_phase_acc_test.sv
module dds_lane_phase_acc_test;
  localparam int LANES = 4;
  localparam int PW    = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                sample_en = 1'b0;
  logic                sync_in = 1'b0;
  logic [PW-1:0]       freq_word = '0;
  logic [PW-1:0]       phase_init = '0;
  logic [LANES*PW-1:0] lane_phase;
  logic                phase_valid;

  int tests = 0;
  int fails = 0;

  logic [PW-1:0] m_base, m_fw, m_init;
  logic          m_valid, m_zero;
  int            m_run;

  dds_lane_phase_acc #(.LANES(LANES), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sync_in(sync_in),
    .freq_word(freq_word), .phase_init(phase_init),
    .lane_phase(lane_phase), .phase_valid(phase_valid)
  );

  always #5 clk = ~clk;

  task automatic compare(input string tag);
    logic [LANES*PW-1:0] exp;
    for (int k = 0; k < LANES; k++)
      exp[k*PW +: PW] = m_zero ? '0 : PW'(m_base + k * m_fw);
    tests++;
    if (lane_phase !== exp || phase_valid !== m_valid) begin
      fails++;
      $display("FAIL %s: lanes=%h valid=%b expected lanes=%h valid=%b",
               tag, lane_phase, phase_valid, exp, m_valid);
    end
  endtask

  task automatic step(input logic s, input logic en, input string tag);
    logic hold;
    @(negedge clk);
    sync_in = s;
    sample_en = en;
    hold = s || (m_run != 0 && m_run < LANES);
    if (hold) begin
      m_run = (m_run < LANES) ? m_run + 1 : LANES;
      m_valid = 1'b0;
      m_zero = 1'b1;
    end else begin
      m_run = 0;
      if (!m_valid || freq_word != m_fw || phase_init != m_init) begin
        m_fw = freq_word; m_init = phase_init; m_base = phase_init;
        m_valid = 1'b1; m_zero = 1'b0;
      end else if (en) begin
        m_base = PW'(m_base + LANES * m_fw);
      end
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_base = '0; m_fw = '0; m_init = '0; m_valid = 1'b0; m_zero = 1'b1; m_run = 0;
    freq_word = 16'h0123; phase_init = 16'h0040;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    step(1'b0, 1'b0, "R2 first alignment");
    for (int j = 0; j < 6; j++) step(1'b0, 1'b1, "R3 advance");
    step(1'b0, 1'b0, "R5 hold when disabled");
    step(1'b0, 1'b0, "R5 hold when disabled");

    freq_word = 16'hFFFF; phase_init = 16'hFFF0;
    step(1'b0, 1'b0, "R6 realign on reprogram");
    for (int j = 0; j < 5; j++) step(1'b0, 1'b1, "R4 wrap negative step");

    for (int i = 0; i < 48; i++) begin
      freq_word  = PW'(i * 16'h1357 + 16'h00F1);
      phase_init = PW'(i * 16'h2B01);
      step(1'b0, (i % 2) == 1, "R6 realign on reprogram");
      for (int j = 0; j < 8; j++)
        step(1'b0, (j % 3) != 0, (j % 3) != 0 ? "R3 advance" : "R5 hold when disabled");
    end

    freq_word = 16'h8000; phase_init = 16'h7FFF;
    step(1'b0, 1'b1, "R6 realign on reprogram");
    for (int j = 0; j < 4; j++) step(1'b0, 1'b1, "R4 wrap half step");

    for (int w = 1; w <= LANES + 3; w++) begin
      freq_word  = PW'(16'h0101 * w);
      phase_init = PW'(16'h1000 * w);
      step(1'b0, 1'b1, "R6 realign on reprogram");
      step(1'b0, 1'b1, "R3 advance");
      for (int j = 0; j < w; j++) step(1'b1, 1'b1, "R7 sync hold");
      for (int j = w; j < LANES; j++) step(1'b0, 1'b1, "R8 stretched hold");
      step(1'b0, 1'b1, "R9 valid returns after hold");
      step(1'b0, 1'b1, "R3 advance");
    end

    freq_word = 16'h0777; phase_init = 16'h0003;
    step(1'b1, 1'b0, "R7 sync hold with changed settings");
    for (int j = 1; j < LANES; j++) step(1'b0, 1'b0, "R8 stretched hold");
    step(1'b0, 1'b0, "R9 valid returns after hold");
    step(1'b0, 1'b1, "R3 advance");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule